// File: doc/BRIEF.md
# Receive-side XON/XOFF pacing controller

This block paces a host that streams bytes into a UART receiver backed by a 16-byte FIFO. The FIFO raises a half-full flag once eight or more bytes are waiting. While the consumer is stalled, for example during a flash page program of up to 5 ms, around 57 characters can arrive at 115200 baud, 8N1. That is far more than the FIFO can absorb, so the host has to be told to pause and later to resume.

The controller compares the half-full flag with a registered copy of itself and latches a pending event whenever the flag moves in either direction. The event line serves as an interrupt. When the servicing agent pulses the acknowledge, the controller reads the flag level at that moment. A high level queues the pause character (0x13) and a low level queues the resume character (0x11). The byte is then offered to a UART transmitter through a request that is held until the transmitter takes it. Two rules apply to a queued byte. A later service replaces a byte that is still waiting. A byte that would repeat the last accepted character is never sent.

Top module: `xonxoff_pacer`

## Requirements
- R1: After reset `evt_irq` and `tx_req` are low, and the last accepted character counts as resume (0x11). A service made with the flag low therefore sends nothing.
- R2: A change of `rx_half_full` in either direction makes `evt_irq` high from the clock edge that follows the change.
- R3: `evt_irq` stays high until an `evt_ack` pulse arrives in a cycle with no new flag change. If an acknowledge and a change fall in the same cycle, the event stays set.
- R4: An `evt_ack` while `evt_irq` is high services the event. With the flag high it queues 0x13 on `tx_data`, and with the flag low it queues 0x11. `tx_req` rises at the next edge.
- R5: While `tx_req` is high and `tx_ready` is low, `tx_req` and `tx_data` stay unchanged unless a new service occurs. A cycle with both high hands the byte over, and `tx_req` falls at the next edge.
- R6: A service made while a byte is still waiting replaces that byte. If the new character equals the last accepted one, the request is withdrawn.
- R7: The transmitter never accepts the same character twice in a row.
- R8: An `evt_ack` while `evt_irq` is low has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_half_full | input | 1 | Receive FIFO holds at least 8 bytes |
| evt_ack | input | 1 | Service pulse for the pending event |
| tx_ready | input | 1 | Transmitter can take a byte this cycle |
| evt_irq | output | 1 | Pending flag-change event |
| tx_req | output | 1 | Byte send request |
| tx_data | output | 8 | Flow-control character to send |

## Verification
The hardest situation to reach is a queued character being overtaken by a second flag change before the transmitter frees up. The byte must then be replaced, or withdrawn when it would repeat the previous character. The bench holds `tx_ready` low for a long stretch. Inside that stretch it toggles the flag and services each event, and only then releases the transmitter. A separate step lands an acknowledge in the very cycle of a flag change.

// File: rtl/xonxoff_pacer.sv
module xonxoff_pacer #(
  parameter logic [7:0] PAUSE_CHAR  = 8'h13,
  parameter logic [7:0] RESUME_CHAR = 8'h11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_half_full,
  input  logic       evt_ack,
  input  logic       tx_ready,
  output logic       evt_irq,
  output logic       tx_req,
  output logic [7:0] tx_data
);

  logic       flag_q;
  logic [7:0] last_sent;

  wire       flag_moved = rx_half_full ^ flag_q;
  wire       serve      = evt_ack & evt_irq;
  wire       handed     = tx_req & tx_ready;
  wire [7:0] want       = rx_half_full ? PAUSE_CHAR : RESUME_CHAR;
  wire [7:0] ref_char   = handed ? tx_data : last_sent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      evt_irq <= 1'b0;
    end else begin
      flag_q <= rx_half_full;
      if (flag_moved)   evt_irq <= 1'b1;
      else if (evt_ack) evt_irq <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_req    <= 1'b0;
      tx_data   <= RESUME_CHAR;
      last_sent <= RESUME_CHAR;
    end else begin
      if (handed) begin
        last_sent <= tx_data;
        tx_req    <= 1'b0;
      end
      if (serve) begin
        tx_data <= want;
        tx_req  <= (want != ref_char);
      end
    end
  end

  p_evt_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_moved |=> evt_irq);

  p_evt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq && !evt_ack |=> evt_irq);

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_ready && !serve |=> tx_req && $stable(tx_data));

  p_req_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_ready && !serve |=> !tx_req);

  p_no_repeat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    handed |-> tx_data != last_sent);

  p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack && !evt_irq && !tx_req |=> !tx_req);

endmodule

// File: tb/tb_xonxoff_pacer.sv
module tb_xonxoff_pacer;
  logic clk = 0, rst_n = 0, hf = 0, ack = 0, rdy = 0;
  logic irq, req;
  logic [7:0] data;
  int checks = 0, errors = 0;
  logic [7:0] got[$];

  xonxoff_pacer dut (.clk(clk), .rst_n(rst_n), .rx_half_full(hf), .evt_ack(ack),
    .tx_ready(rdy), .evt_irq(irq), .tx_req(req), .tx_data(data));

  always #10 clk = ~clk;

  // behavioural reference
  bit m_hf, m_evt, m_req;
  int m_data, m_last;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_hf = 0; m_evt = 0; m_req = 0; m_data = 'h11; m_last = 'h11;
    end else begin
      bit acc, srv;
      int refc, w;
      if (req && rdy) got.push_back(data);
      acc = m_req && rdy;
      srv = ack && m_evt;
      refc = acc ? m_data : m_last;
      if (acc) begin m_last = m_data; m_req = 0; end
      if (srv) begin
        w = hf ? 'h13 : 'h11;
        m_data = w;
        m_req = (w != refc);
      end
      if (hf != m_hf) m_evt = 1;
      else if (ack) m_evt = 0;
      m_hf = hf;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    @(negedge clk);
    chk({tag, " irq R2/R3"}, irq, m_evt);
    chk({tag, " req R4/R5/R6"}, req, m_req);
    if (m_req) chk({tag, " data R4/R6"}, data, m_data);
  endtask

  task automatic set(input bit h, input bit a, input bit r);
    hf = h; ack = a; rdy = r;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset R1 irq", irq, 0);
    chk("reset R1 req", req, 0);
    // R1: a low-flag service right after reset sends nothing
    set(0, 1, 1); cyc("r1");
    set(0, 0, 1); cyc("r1");
    chk("R1 no send", got.size(), 0);
    // R8: ack while idle
    set(0, 1, 0); cyc("r8");
    set(0, 0, 0); cyc("r8");
    chk("R8 irq", irq, 0);
    chk("R8 req", req, 0);
    // R2/R4: rising flag, service, send pause
    set(1, 0, 1); cyc("r2"); chk("R2 rise irq", irq, 1);
    set(1, 1, 1); cyc("r4"); chk("R4 pause data", data, 'h13); chk("R4 req", req, 1);
    set(1, 0, 1); cyc("r4"); chk("R5 drop", req, 0);
    // falling flag, resume
    set(0, 0, 1); cyc("r2"); chk("R2 fall irq", irq, 1);
    repeat (3) cyc("r3");
    chk("R3 hold", irq, 1);
    set(0, 1, 1); cyc("r4"); chk("R4 resume data", data, 'h11);
    set(0, 0, 1); cyc("r4");
    // R3: ack in the very cycle of a change
    set(1, 1, 0); cyc("r3"); chk("R3 ack+change", irq, 1);
    // R5: held while not ready
    set(1, 1, 0); cyc("r5");
    set(1, 0, 0);
    repeat (5) cyc("r5");
    chk("R5 held req", req, 1); chk("R5 held data", data, 'h13);
    // R6: flag falls, serviced while waiting -> withdrawn
    set(0, 0, 0); cyc("r6");
    set(0, 1, 0); cyc("r6"); chk("R6 withdrawn", req, 0);
    set(0, 0, 1); repeat (3) cyc("r6");
    // R6 replace: up, wait, down-up again
    set(1, 0, 0); cyc("r6");
    set(1, 1, 0); cyc("r6");
    set(0, 0, 0); cyc("r6");
    set(0, 1, 0); cyc("r6");
    set(1, 0, 0); cyc("r6");
    set(1, 1, 0); cyc("r6"); chk("R6 replace", data, 'h13);
    set(1, 0, 1); repeat (3) cyc("r6");
    set(0, 0, 1); cyc("r4");
    set(0, 1, 1); repeat (2) cyc("r4");
    set(0, 0, 1); repeat (3) cyc("end");
    chk("R7 count", got.size(), 4);
    for (int i = 0; i < got.size(); i++) begin
      chk("R7 order", got[i], (i % 2 == 0) ? 'h13 : 'h11);
      if (i > 0) chk("R7 no repeat", got[i] != got[i-1], 1);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule